// File: doc/BRIEF.md
# Capability Fault Entry Unit

This unit sits beside the pipeline of a processor that carries capabilities: fat pointers with a tag, permission bits, an object type and base/length/offset fields. Instruction decode and the memory checks raise fault requests on one or more request lanes. Each request carries a fault kind and, when applicable, the number of the capability register involved. The unit turns the winning request into a 16-bit cause value and saves the current program-counter capability, with its offset replaced by the faulting PC, into the exception capability slot. It then steers both the next and the delayed program-counter capability to the kernel code capability. The base processor handles vectoring. It receives only an exception-valid pulse, a two-bit exception class and a coprocessor-error field.

The unit also answers, combinationally, whether a capability register number may be touched. Registers 27 to 31 are reserved for the kernel, and each is gated by its own access bit in the current program-counter capability. A checked access to a denied register becomes a fault with a per-register code. An exception-return request reloads the next and delayed program-counter capabilities from the saved exception capability. When the capability unit is marked unusable, any request produces a coprocessor-unusable exception instead of a capability fault, and the cause register is left untouched.

Top module: `cap_fault_entry`

## Requirements
- R1: After reset the cause register, the saved exception capability and the next and delayed program-counter capabilities are all zero, and no exception is signalled.
- R2: On a taken fault (capability unit usable) cause[15:8] is set from the fault kind. Kinds 0..10 (none, length, tag, seal, type, call trap, return trap, stack underflow, user-defined, no-store-cap translation, inexact bounds) give codes 0x00..0x0a equal to the kind. Kinds 11..18 (global, execute, load, store, load-cap, store-cap, store-local-cap, seal permission) give 0x10..0x17. Kinds 19..31 give 0x00.
- R3: cause[7:0] holds the 5-bit register number zero-extended when the request is tied to a register, and 0xff when it is not.
- R4: One cycle after any taken request, excValid is high for one cycle. The class is 2 (trap) for kinds 5 and 6 and 1 (capability error) for every other fault. The class is 0 when no exception is signalled.
- R5: On exception entry the saved exception capability becomes the program-counter capability with bits 191:128 (offset) replaced by the PC. The next and delayed program-counter capabilities both become the kernel code capability. All of this is visible one cycle later.
- R6: On exception return with no fault in the same cycle, the next and delayed program-counter capabilities both become the saved exception capability, and the saved exception capability itself is not changed.
- R7: accessOk is combinational. Register 27 needs program-counter capability bit 206, register 28 bit 207, register 29 bit 205, register 30 bit 204 and register 31 bit 203. Registers 0..26 are always accessible.
- R8: A checked access to a denied register, with no lane fault in the same cycle, takes an exception of class 1. Its cause code is 0x1d for register 27, 0x1e for 28, 0x1c for 29, 0x1b for 30 and 0x1a for 31, and the register number goes in cause[7:0].
- R9: When the capability unit is not usable, any request gives class 3 (coprocessor unusable) with ceField = 2. Entry per R5 still takes place, and the cause register keeps its value. ceField is 0 otherwise.
- R10: Among simultaneous lane faults the lowest lane index wins. Any lane fault wins over a denied access check, and any exception wins over an exception return.
- R11: The cause register keeps its value on every cycle without a taken fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultValid | input | LANES | Per-lane single-cycle fault pulse |
| faultKind | input | 5*LANES | Per-lane fault kind, lane i at [5i+4:5i] |
| faultRegTied | input | LANES | Per-lane: fault names a register |
| faultReg | input | 5*LANES | Per-lane register number |
| accChkValid | input | 1 | Checked access to a capability register |
| accChkReg | input | 5 | Register number for the access check |
| cu2Usable | input | 1 | Capability unit usable status bit |
| eretValid | input | 1 | Exception return request |
| pccIn | input | 3*XLEN+65 | Current program-counter capability |
| pcIn | input | XLEN | Current PC value |
| kccIn | input | 3*XLEN+65 | Kernel code capability (register 29) |
| accessOk | output | 1 | Access check result for accChkReg |
| causeOut | output | 16 | Cause register {code, register} |
| epccOut | output | 3*XLEN+65 | Saved exception capability (register 31) |
| nextPccOut | output | 3*XLEN+65 | Next program-counter capability |
| delayedPccOut | output | 3*XLEN+65 | Delayed program-counter capability |
| excValid | output | 1 | Exception taken pulse |
| excClass | output | 2 | 0 none, 1 capability error, 2 trap, 3 unusable |
| ceField | output | 2 | Coprocessor-error field |

## Verification
A wrong lane-priority choice or code mapping shows in causeOut one cycle after the request. A missed or stale capability save shows in epccOut at the same edge, and it resurfaces on nextPccOut and delayedPccOut at the next exception return, so even a corrupted saved state that is not observed at once is caught later. A bad permission decode shows at once on accessOk, and one cycle later as a spurious or missing exception with its cause code. Because every cycle compares all registered outputs with the bench model, any divergence is flagged at the first edge where it reaches a port.

// File: rtl/cfe_pkg.sv
package cfe_pkg;

  typedef enum logic [4:0] {
    FK_NONE       = 5'd0,
    FK_LENGTH     = 5'd1,
    FK_TAG        = 5'd2,
    FK_SEAL       = 5'd3,
    FK_TYPE       = 5'd4,
    FK_CALL       = 5'd5,
    FK_RETURN     = 5'd6,
    FK_UNDERFLOW  = 5'd7,
    FK_USERDEF    = 5'd8,
    FK_NOSTORECAP = 5'd9,
    FK_INEXACT    = 5'd10,
    FK_GLOBAL     = 5'd11,
    FK_EXEC       = 5'd12,
    FK_LOAD       = 5'd13,
    FK_STORE      = 5'd14,
    FK_LOADCAP    = 5'd15,
    FK_STORECAP   = 5'd16,
    FK_STORELOCAL = 5'd17,
    FK_SEALPERM   = 5'd18
  } faultKindE;

  typedef enum logic [1:0] {
    EXC_NONE       = 2'd0,
    EXC_CAPERR     = 2'd1,
    EXC_TRAP       = 2'd2,
    EXC_CPUNUSABLE = 2'd3
  } excClassE;

  typedef struct packed {
    logic        entryEn;
    logic        returnEn;
    logic        causeWe;
    logic [15:0] causeVal;
  } strobeT;

  localparam logic [7:0] NO_REG_FIELD  = 8'hff;
  localparam logic [1:0] CE_CAP_UNIT   = 2'd2;
  localparam logic [4:0] FIRST_GUARDED = 5'd27;

  // Sparse code map: a dense low group, then a second group starting at 0x10.
  function automatic logic [7:0] kindToCode(input logic [4:0] kind);
    logic [7:0] wide;
    wide = {3'b000, kind};
    if (kind <= FK_INEXACT)        return wide;
    else if (kind <= FK_SEALPERM)  return wide + 8'd5;
    else                           return 8'h00;
  endfunction

  function automatic logic [7:0] accessCode(input logic [4:0] regNum);
    case (regNum)
      5'd27:   return 8'h1d;
      5'd28:   return 8'h1e;
      5'd29:   return 8'h1c;
      5'd30:   return 8'h1b;
      5'd31:   return 8'h1a;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfe_perm.sv
module cfe_perm #(
  parameter int XLEN = 64
) (
  input  logic [3*XLEN+64:0] pccIn,
  input  logic [4:0]         chkReg,
  output logic               accessOk
);
  localparam int PERM_LSB  = 3*XLEN + 1;
  localparam int BIT_EPCC  = PERM_LSB + 10;
  localparam int BIT_KDC   = PERM_LSB + 11;
  localparam int BIT_KCC   = PERM_LSB + 12;
  localparam int BIT_KR1   = PERM_LSB + 13;
  localparam int BIT_KR2   = PERM_LSB + 14;

  always_comb begin
    case (chkReg)
      5'd27:   accessOk = pccIn[BIT_KR1];
      5'd28:   accessOk = pccIn[BIT_KR2];
      5'd29:   accessOk = pccIn[BIT_KCC];
      5'd30:   accessOk = pccIn[BIT_KDC];
      5'd31:   accessOk = pccIn[BIT_EPCC];
      default: accessOk = 1'b1;
    endcase
  end
endmodule

// File: rtl/cfe_ctrl.sv
module cfe_ctrl
  import cfe_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   faultValid,
  input  logic [5*LANES-1:0] faultKind,
  input  logic [LANES-1:0]   faultRegTied,
  input  logic [5*LANES-1:0] faultReg,
  input  logic               accChkValid,
  input  logic [4:0]         accChkReg,
  input  logic               accessOk,
  input  logic               cu2Usable,
  input  logic               eretValid,
  output strobeT             strb,
  output logic               excValid,
  output logic [1:0]         excClass,
  output logic [1:0]         ceField
);
  logic [15:0] laneCause [LANES];
  logic        laneTrap  [LANES];

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      logic [4:0] kindG;
      logic [4:0] regG;
      assign kindG = faultKind[5*g +: 5];
      assign regG  = faultReg[5*g +: 5];
      assign laneCause[g] = {kindToCode(kindG),
                             faultRegTied[g] ? {3'b000, regG} : NO_REG_FIELD};
      assign laneTrap[g]  = (kindG == FK_CALL) || (kindG == FK_RETURN);
    end
  endgenerate

  logic [15:0] winCause;
  logic        winTrap;
  logic        anyFault;
  logic        accDenied;
  logic        anyReq;
  excClassE    classNext;

  always_comb begin
    winCause = '0;
    winTrap  = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (faultValid[i]) begin
        winCause = laneCause[i];
        winTrap  = laneTrap[i];
      end
    end
  end

  assign anyFault  = |faultValid;
  assign accDenied = accChkValid && !accessOk;
  assign anyReq    = anyFault || accDenied;

  always_comb begin
    strb.entryEn  = anyReq;
    strb.returnEn = eretValid && !anyReq;
    strb.causeWe  = anyReq && cu2Usable;
    strb.causeVal = anyFault ? winCause
                             : {accessCode(accChkReg), 3'b000, accChkReg};
  end

  always_comb begin
    if (!anyReq)        classNext = EXC_NONE;
    else if (!cu2Usable) classNext = EXC_CPUNUSABLE;
    else if (anyFault && winTrap) classNext = EXC_TRAP;
    else                classNext = EXC_CAPERR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excValid <= 1'b0;
      excClass <= EXC_NONE;
      ceField  <= 2'd0;
    end else begin
      excValid <= anyReq;
      excClass <= classNext;
      ceField  <= (classNext == EXC_CPUNUSABLE) ? CE_CAP_UNIT : 2'd0;
    end
  end

  AST_VALID_HAS_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excClass != EXC_NONE)); // R4
  AST_CE_ONLY_UNUSABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ceField != 2'd0) |-> (excClass == EXC_CPUNUSABLE)); // R9
  AST_ENTRY_BEATS_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.entryEn && strb.returnEn)); // R10
  AST_UNUSABLE_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    !cu2Usable |-> !strb.causeWe); // R9
endmodule

// File: rtl/cfe_datapath.sv
module cfe_datapath
  import cfe_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strb,
  input  logic [3*XLEN+64:0] pccIn,
  input  logic [XLEN-1:0]    pcIn,
  input  logic [3*XLEN+64:0] kccIn,
  output logic [15:0]        causeQ,
  output logic [3*XLEN+64:0] epccQ,
  output logic [3*XLEN+64:0] nextPccQ,
  output logic [3*XLEN+64:0] delayedPccQ
);
  localparam int CAP_W   = 3*XLEN + 65;
  localparam int OFF_LSB = 2*XLEN;

  logic [CAP_W-1:0] savedCap;

  always_comb begin
    savedCap = pccIn;
    savedCap[OFF_LSB +: XLEN] = pcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ      <= '0;
      epccQ       <= '0;
      nextPccQ    <= '0;
      delayedPccQ <= '0;
    end else begin
      if (strb.causeWe) causeQ <= strb.causeVal;
      if (strb.entryEn) begin
        epccQ       <= savedCap;
        nextPccQ    <= kccIn;
        delayedPccQ <= kccIn;
      end else if (strb.returnEn) begin
        nextPccQ    <= epccQ;
        delayedPccQ <= epccQ;
      end
    end
  end

  AST_ENTRY_KCC: assert property (@(posedge clk) disable iff (!rstN)
    strb.entryEn |=> (nextPccQ == $past(kccIn)) && (delayedPccQ == $past(kccIn))); // R5
  AST_ENTRY_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    strb.entryEn |=> (epccQ[OFF_LSB +: XLEN] == $past(pcIn))); // R5
  AST_RETURN_EPCC: assert property (@(posedge clk) disable iff (!rstN)
    strb.returnEn |=> (nextPccQ == $past(epccQ)) && (delayedPccQ == $past(epccQ))); // R6
  AST_EPCC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.entryEn |=> $stable(epccQ)); // R6
  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.causeWe |=> $stable(causeQ)); // R11
endmodule

// File: rtl/cap_fault_entry.sv
module cap_fault_entry
  import cfe_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LANES-1:0]   faultValid,
  input  logic [5*LANES-1:0] faultKind,
  input  logic [LANES-1:0]   faultRegTied,
  input  logic [5*LANES-1:0] faultReg,
  input  logic               accChkValid,
  input  logic [4:0]         accChkReg,
  input  logic               cu2Usable,
  input  logic               eretValid,
  input  logic [3*XLEN+64:0] pccIn,
  input  logic [XLEN-1:0]    pcIn,
  input  logic [3*XLEN+64:0] kccIn,
  output logic               accessOk,
  output logic [15:0]        causeOut,
  output logic [3*XLEN+64:0] epccOut,
  output logic [3*XLEN+64:0] nextPccOut,
  output logic [3*XLEN+64:0] delayedPccOut,
  output logic               excValid,
  output logic [1:0]         excClass,
  output logic [1:0]         ceField
);
  strobeT strb;

  cfe_perm #(.XLEN(XLEN)) u_perm (
    .pccIn    (pccIn),
    .chkReg   (accChkReg),
    .accessOk (accessOk)
  );

  cfe_ctrl #(.LANES(LANES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .faultValid   (faultValid),
    .faultKind    (faultKind),
    .faultRegTied (faultRegTied),
    .faultReg     (faultReg),
    .accChkValid  (accChkValid),
    .accChkReg    (accChkReg),
    .accessOk     (accessOk),
    .cu2Usable    (cu2Usable),
    .eretValid    (eretValid),
    .strb         (strb),
    .excValid     (excValid),
    .excClass     (excClass),
    .ceField      (ceField)
  );

  cfe_datapath #(.XLEN(XLEN)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pccIn       (pccIn),
    .pcIn        (pcIn),
    .kccIn       (kccIn),
    .causeQ      (causeOut),
    .epccQ       (epccOut),
    .nextPccQ    (nextPccOut),
    .delayedPccQ (delayedPccOut)
  );

  AST_LOW_REGS_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (accChkReg < FIRST_GUARDED) |-> accessOk); // R7
endmodule

// File: tb/cap_fault_entry_bench.sv
module cap_fault_entry_bench;
  localparam int XLEN  = 64;
  localparam int LANES = 2;
  localparam int CAPW  = 3*XLEN + 65;
  localparam int OFF   = 2*XLEN;
  localparam int PERM  = 3*XLEN + 1;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [LANES-1:0]   faultValid = '0;
  logic [5*LANES-1:0] faultKind = '0;
  logic [LANES-1:0]   faultRegTied = '0;
  logic [5*LANES-1:0] faultReg = '0;
  logic               accChkValid = 1'b0;
  logic [4:0]         accChkReg = '0;
  logic               cu2Usable = 1'b1;
  logic               eretValid = 1'b0;
  logic [CAPW-1:0]    pccIn = '0;
  logic [XLEN-1:0]    pcIn = '0;
  logic [CAPW-1:0]    kccIn = '0;
  logic               accessOk;
  logic [15:0]        causeOut;
  logic [CAPW-1:0]    epccOut, nextPccOut, delayedPccOut;
  logic               excValid;
  logic [1:0]         excClass, ceField;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [15:0]     mCause = '0;
  logic [CAPW-1:0] mEpcc = '0, mNext = '0, mDelayed = '0;
  logic            mValid = 1'b0;
  logic [1:0]      mClass = '0, mCe = '0;

  always #2 clk = ~clk;

  cap_fault_entry #(.XLEN(XLEN), .LANES(LANES)) u_cap_fault_entry (
    .clk(clk), .rstN(rstN), .faultValid(faultValid), .faultKind(faultKind),
    .faultRegTied(faultRegTied), .faultReg(faultReg), .accChkValid(accChkValid),
    .accChkReg(accChkReg), .cu2Usable(cu2Usable), .eretValid(eretValid),
    .pccIn(pccIn), .pcIn(pcIn), .kccIn(kccIn), .accessOk(accessOk),
    .causeOut(causeOut), .epccOut(epccOut), .nextPccOut(nextPccOut),
    .delayedPccOut(delayedPccOut), .excValid(excValid), .excClass(excClass),
    .ceField(ceField)
  );

  function automatic logic [7:0] expCode(input logic [4:0] k);
    if (k <= 5'd10) return {3'b000, k};
    if (k <= 5'd18) return 8'h10 + {3'b000, k} - 8'd11;
    return 8'h00;
  endfunction

  function automatic logic [7:0] expAccCode(input logic [4:0] r);
    case (r)
      5'd31: return 8'h1a;
      5'd30: return 8'h1b;
      5'd29: return 8'h1c;
      5'd27: return 8'h1d;
      5'd28: return 8'h1e;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic expAllowed(input logic [4:0] r, input logic [CAPW-1:0] c);
    case (r)
      5'd27: return c[206];
      5'd28: return c[207];
      5'd29: return c[205];
      5'd30: return c[204];
      5'd31: return c[203];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [CAPW-1:0] randCap();
    logic [CAPW-1:0] r = '0;
    for (int i = 0; i < 9; i++) r = {r[CAPW-33:0], $urandom()};
    return r;
  endfunction

  task automatic check(input logic [CAPW-1:0] act, input logic [CAPW-1:0] exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Apply current inputs for one cycle, update model, compare outputs.
  task automatic step();
    logic anyF, den, req, trap;
    logic [15:0] wc;
    int win;
    #1;
    check(CAPW'(accessOk), CAPW'(expAllowed(accChkReg, pccIn)), "R7 accessOk");
    anyF = |faultValid;
    den  = accChkValid && !expAllowed(accChkReg, pccIn);
    req  = anyF || den;
    win  = -1;
    for (int i = 0; i < LANES; i++) if (faultValid[i] && win < 0) win = i;
    wc = '0; trap = 1'b0;
    if (win >= 0) begin
      wc = {expCode(faultKind[5*win +: 5]),
            faultRegTied[win] ? {3'b000, faultReg[5*win +: 5]} : 8'hff};
      trap = (faultKind[5*win +: 5] == 5'd5) || (faultKind[5*win +: 5] == 5'd6);
    end else if (den) begin
      wc = {expAccCode(accChkReg), 3'b000, accChkReg};
    end
    mValid = req;
    mCe = 2'd0;
    if (req) begin
      mNext = kccIn; mDelayed = kccIn;
      mEpcc = pccIn; mEpcc[OFF +: XLEN] = pcIn;
      if (!cu2Usable) begin mClass = 2'd3; mCe = 2'd2; end
      else begin mCause = wc; mClass = trap ? 2'd2 : 2'd1; end
    end else begin
      mClass = 2'd0;
      if (eretValid) begin mNext = mEpcc; mDelayed = mEpcc; end
    end
    @(posedge clk);
    @(negedge clk);
    check(CAPW'(causeOut), CAPW'(mCause), "R2 R3 R8 R10 R11 causeOut");
    check(epccOut, mEpcc, "R5 epccOut");
    check(nextPccOut, mNext, "R5 R6 nextPccOut");
    check(delayedPccOut, mDelayed, "R5 R6 delayedPccOut");
    check(CAPW'(excValid), CAPW'(mValid), "R4 excValid");
    check(CAPW'(excClass), CAPW'(mClass), "R4 R9 R10 excClass");
    check(CAPW'(ceField), CAPW'(mCe), "R9 ceField");
  endtask

  task automatic idle();
    faultValid = '0; accChkValid = 1'b0; eretValid = 1'b0; cu2Usable = 1'b1;
  endtask

  task automatic newCaps();
    pccIn = randCap(); kccIn = randCap(); pcIn = {$urandom(), $urandom()};
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(CAPW'(causeOut), '0, "R1 cause after reset");
    check(epccOut, '0, "R1 epcc after reset");
    check(nextPccOut, '0, "R1 next after reset");
    check(delayedPccOut, '0, "R1 delayed after reset");
    check(CAPW'(excValid), '0, "R1 excValid after reset");

    // R2 R3 R4: every kind on lane 0, tied and untied
    for (int k = 0; k < 32; k++) begin
      idle(); newCaps();
      faultValid = 2'b01; faultKind[4:0] = 5'(k);
      faultRegTied = 2'(k & 1); faultReg[4:0] = 5'($urandom());
      step();
    end
    // R10 lane priority: both lanes fire
    idle(); newCaps();
    faultValid = 2'b11; faultKind = {5'd13, 5'd5}; faultRegTied = 2'b11; faultReg = {5'd9, 5'd3};
    step();
    // R10 lane 1 alone
    idle(); faultValid = 2'b10; step();
    // R7 R8: access checks on guarded and unguarded registers
    for (int r = 24; r < 32; r++) begin
      for (int b = 0; b < 2; b++) begin
        idle(); newCaps();
        pccIn[PERM+14:PERM+10] = b ? 5'b11111 : 5'b00000;
        accChkValid = 1'b1; accChkReg = 5'(r);
        step();
      end
    end
    // R10 fault beats access violation
    idle(); newCaps(); pccIn[PERM+14:PERM+10] = '0;
    accChkValid = 1'b1; accChkReg = 5'd31;
    faultValid = 2'b10; faultKind = {5'd2, 5'd0}; faultRegTied = 2'b00;
    step();
    // R9 unusable with a fault
    idle(); newCaps(); cu2Usable = 1'b0; faultValid = 2'b01; faultKind[4:0] = 5'd1; step();
    // R6 return, then return with fault (R10)
    idle(); eretValid = 1'b1; step();
    idle(); newCaps(); eretValid = 1'b1; faultValid = 2'b01; faultKind[4:0] = 5'd3; step();
    idle(); eretValid = 1'b1; step();
    // R11 idle holds
    idle(); repeat (3) step();

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      if ($urandom_range(0, 3) == 0) newCaps();
      faultValid   = ($urandom_range(0, 2) == 0) ? 2'($urandom()) : 2'b00;
      faultKind    = 10'($urandom());
      faultRegTied = 2'($urandom());
      faultReg     = 10'($urandom());
      accChkValid  = ($urandom_range(0, 3) == 0);
      accChkReg    = 5'($urandom_range(20, 31));
      cu2Usable    = ($urandom_range(0, 7) != 0);
      eretValid    = ($urandom_range(0, 4) == 0);
      step();
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule